// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

One up-counter drives two pulse-width outputs, A and B. The counter advances on a tick taken from a selectable divided clock or from an external slow tick. It wraps to zero after its value has equalled the period register. Each output has its own duty compare register. Each output also has three 2-bit action codes: one for its duty compare, one for the period compare and one for a software trigger. Every action code means none, set, clear or toggle.

Software loads a mode word and three registers through a simple write port. A 3-bit command port starts the counter clock, stops it, and issues a software trigger. The three command bits may be combined in one command. The trigger zeroes the counter and forces each output to its trigger level. This gives a fixed level when no compare actions are programmed, which covers a duty of zero or a duty equal to the period. For a normal-polarity PWM, the duty compare clears the output and the period compare sets it. For an inverted PWM, the two actions are swapped.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset the counter reads 0, both outputs are low and the counter clock is stopped, so the count stays 0 until an enable command.
- R2: Command bit 0 enables the counter clock and bit 1 disables it. Disable wins when both bits are set. The new clock state applies from the next cycle on.
- R3: Mode bits [2:0] select the tick. Values 0 to 3 give one tick every 4^k cycles (1, 4, 16, 64). Value 4 passes the slow_tick_i pulses through. Values 5 to 7 give no ticks.
- R4: On each tick the counter adds one. If the counter value before the tick equals the period register, it goes to 0 instead.
- R5: Action codes are 0 none, 1 set, 2 clear, 3 toggle. The mode word holds, for output A, the duty action in [4:3], the period action in [6:5] and the trigger action in [8:7]. Output B uses [10:9], [12:11] and [14:13] in the same order.
- R6: On a tick where the counter value before the tick equals the duty register of an output, that output applies its duty action.
- R7: On a tick where the counter equals the period register, both outputs apply their period action. If the duty compare matches in the same tick, only the period action is applied.
- R8: Command bit 2 zeroes the counter and applies each output's trigger action at the next edge. This holds whether the clock is running or stopped, and it overrides any compare in the same cycle.
- R9: While the clock is stopped, the counter and both outputs hold their values.
- R10: With both compare actions set to none, an output stays at the level its trigger action set while the counter runs.
- R11: Write address 0 loads the mode word, 1 the duty register of A, 2 the duty register of B and 3 the period register. Ticks after the write use the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 mode, 1 duty A, 2 duty B, 3 period |
| wr_data_i | input | DATA_W (16) | Write data |
| cmd_i | input | 3 | Bit 0 clock enable, bit 1 clock disable, bit 2 software trigger |
| slow_tick_i | input | 1 | Single-cycle slow tick pulse, used with select value 4 |
| count_o | output | CNT_W (16) | Counter value |
| wave_a_o | output | 1 | Output A |
| wave_b_o | output | 1 | Output B |

## Verification
Two event pairs can land on the same edge: a duty compare with the period compare, and a software trigger with a period compare. The first pair is provoked by loading equal duty and period values, with duty set to clear and period set to set. The output must then stay high after the first wrap. The second pair is provoked by waiting until the count reads the period value and then issuing the trigger for that edge. The counter must read 0, and the output must take the trigger level rather than the level the period action would give.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef struct packed {
    act_e on_trig;
    act_e on_period;
    act_e on_duty;
  } out_cfg_t;

  typedef struct packed {
    out_cfg_t   b;
    out_cfg_t   a;
    logic [2:0] clk_sel;
  } mode_t;

  localparam int MODE_W   = $bits(mode_t);
  localparam int SEL_W    = 3;
  localparam int CMD_EN   = 0;
  localparam int CMD_DIS  = 1;
  localparam int CMD_TRIG = 2;

  function automatic logic apply_act(input act_e act, input logic cur);
    case (act)
      ACT_SET: apply_act = 1'b1;
      ACT_CLR: apply_act = 1'b0;
      ACT_TGL: apply_act = ~cur;
      default: apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/wtc_tick_gen.sv
`timescale 1ns/1ps
module wtc_tick_gen #(
  parameter int STAGES   = 4,
  parameter int STEP_LOG = 2,
  parameter int SEL_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             slow_tick_i,
  output logic             tick_o
);
  localparam int DIV_W = (STAGES > 1) ? STEP_LOG * (STAGES - 1) : 1;

  logic [DIV_W-1:0]  div_q;
  logic [STAGES-1:0] taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_tap
    if (k == 0) begin : g_full
      assign taps[k] = 1'b1;
    end else begin : g_div
      assign taps[k] = (div_q[STEP_LOG*k-1:0] == '0);
    end
  end

  always_comb begin
    tick_o = 1'b0;
    for (int k = 0; k < STAGES; k++) begin
      if (sel_i == SEL_W'(k)) tick_o = taps[k];
    end
    if (sel_i == SEL_W'(STAGES)) tick_o = slow_tick_i;
  end

  if (STAGES > 1) begin : g_chk
    // divide-by-4 select never ticks on two adjacent cycles
    p_tick_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && sel_i == SEL_W'(1)) |=> !(tick_o && sel_i == SEL_W'(1)));
  end
endmodule

// File: rtl/wtc_counter.sv
`timescale 1ns/1ps
module wtc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             period_hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o        = cnt_q;
  assign period_hit_o = (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (step_i) begin
      if (period_hit_o)   cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i && cnt_q == period_i) |=> cnt_q == '0);
  p_incr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i && cnt_q != period_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !restart_i) |=> $stable(cnt_q));
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/wtc_wave_out.sv
`timescale 1ns/1ps
module wtc_wave_out
  import wtc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  out_cfg_t cfg_i,
  input  logic     step_i,
  input  logic     trig_i,
  input  logic     duty_hit_i,
  input  logic     period_hit_i,
  output logic     wave_o
);
  act_e act;
  logic wave_q;

  assign wave_o = wave_q;

  // trigger beats period compare, period compare beats duty compare
  always_comb begin
    act = ACT_NONE;
    if (trig_i)              act = cfg_i.on_trig;
    else if (step_i) begin
      if (period_hit_i)      act = cfg_i.on_period;
      else if (duty_hit_i)   act = cfg_i.on_duty;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= apply_act(act, wave_q);
  end

  p_trig_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && cfg_i.on_trig == ACT_SET) |=> wave_q);
  p_trig_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && cfg_i.on_trig == ACT_CLR) |=> !wave_q);
  p_period_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !trig_i && period_hit_i && duty_hit_i && cfg_i.on_period == ACT_SET) |=> wave_q);
  p_stopped_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !trig_i) |=> $stable(wave_q));
endmodule

// File: rtl/wave_timer_chan.sv
`timescale 1ns/1ps
module wave_timer_chan
  import wtc_pkg::*;
#(
  parameter int  CNT_W        = 16,
  parameter int  PRE_STAGES   = 4,
  parameter int  PRE_STEP_LOG = 2,
  localparam int DATA_W       = (CNT_W > MODE_W) ? CNT_W : MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        cmd_i,
  input  logic              slow_tick_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              wave_a_o,
  output logic              wave_b_o
);
  localparam int NOUT = 2;

  mode_t            mode_q;
  logic [CNT_W-1:0] duty_q [NOUT];
  logic [CNT_W-1:0] period_q;
  logic             clk_on_q;
  logic             tick, step, trig, period_hit;
  logic [CNT_W-1:0] cnt;
  out_cfg_t         cfg   [NOUT];
  logic [NOUT-1:0]  wave;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      duty_q   <= '{default: '0};
      period_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        2'd0: mode_q    <= mode_t'(wr_data_i[MODE_W-1:0]);
        2'd1: duty_q[0] <= wr_data_i[CNT_W-1:0];
        2'd2: duty_q[1] <= wr_data_i[CNT_W-1:0];
        default: period_q <= wr_data_i[CNT_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                clk_on_q <= 1'b0;
    else if (cmd_i[CMD_DIS])    clk_on_q <= 1'b0;
    else if (cmd_i[CMD_EN])     clk_on_q <= 1'b1;
  end

  assign trig = cmd_i[CMD_TRIG];
  assign step = clk_on_q & tick;

  wtc_tick_gen #(
    .STAGES  (PRE_STAGES),
    .STEP_LOG(PRE_STEP_LOG),
    .SEL_W   (SEL_W)
  ) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (mode_q.clk_sel),
    .slow_tick_i(slow_tick_i),
    .tick_o     (tick)
  );

  wtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .restart_i   (trig),
    .period_i    (period_q),
    .cnt_o       (cnt),
    .period_hit_o(period_hit)
  );

  assign cfg[0] = mode_q.a;
  assign cfg[1] = mode_q.b;

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    wtc_wave_out u_wave (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_i       (cfg[i]),
      .step_i      (step),
      .trig_i      (trig),
      .duty_hit_i  (cnt == duty_q[i]),
      .period_hit_i(period_hit),
      .wave_o      (wave[i])
    );
  end

  assign count_o  = cnt;
  assign wave_a_o = wave[0];
  assign wave_b_o = wave[1];

  p_disable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i[CMD_DIS] |=> !clk_on_q);
  p_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i[CMD_EN] && !cmd_i[CMD_DIS]) |=> clk_on_q);
  p_stopped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_on_q && !trig) |=> $stable(count_o));
endmodule

// File: tb/sim_wave_timer_chan.sv
`timescale 1ns/1ps
module sim_wave_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  cmd = '0;
  logic        slow = 1'b0;
  logic [15:0] count;
  logic        wave_a, wave_b;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [1:0] NO = 2'd0, ST = 2'd1, CL = 2'd2, TG = 2'd3;

  always #2.5 clk = ~clk;

  wave_timer_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cmd_i(cmd), .slow_tick_i(slow),
    .count_o(count), .wave_a_o(wave_a), .wave_b_o(wave_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic issue(input logic [2:0] c);
    cmd = c;
    step(1);
    cmd = '0;
  endtask

  function automatic logic [15:0] mk(input logic [2:0] sel,
      input logic [1:0] ad, input logic [1:0] ap, input logic [1:0] at,
      input logic [1:0] bd, input logic [1:0] bp, input logic [1:0] bt);
    return {1'b0, bt, bp, bd, at, ap, ad, sel};
  endfunction

  task automatic t_reset;
    chk(count == 0, "R1 count after reset", int'(count), 0);
    chk(wave_a == 0 && wave_b == 0, "R1 outputs after reset", int'({wave_a, wave_b}), 0);
    wr(3, 16'd9);
    step(6);
    chk(count == 0, "R1 clock stopped after reset", int'(count), 0);
  endtask

  task automatic t_pwm;
    int bad_a = 0, bad_b = 0, bad_c = 0;
    logic [15:0] prev;
    wr(0, mk(3'd0, CL, ST, ST, ST, CL, CL));
    wr(1, 16'd3); wr(2, 16'd6); wr(3, 16'd9);
    issue(3'b101);
    chk(count == 0, "R8 trigger zeroes counter", int'(count), 0);
    chk(wave_a == 1 && wave_b == 0, "R8 trigger levels", int'({wave_a, wave_b}), 2);
    prev = count;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (wave_a != (count <= 16'd3)) bad_a++;
      if (wave_b != (count > 16'd6)) bad_b++;
      if (count != ((prev == 16'd9) ? 16'd0 : prev + 16'd1)) bad_c++;
      prev = count;
    end
    chk(bad_c == 0, "R4 count and wrap sequence", bad_c, 0);
    chk(bad_a == 0, "R6 normal polarity on A", bad_a, 0);
    chk(bad_b == 0, "R7 inverted polarity on B", bad_b, 0);
  endtask

  task automatic t_stop;
    logic [15:0] c1;
    logic a1;
    step(5);
    issue(3'b010);
    c1 = count; a1 = wave_a;
    step(12);
    chk(count == c1 && wave_a == a1, "R9 stopped counter holds", int'(count), int'(c1));
    issue(3'b011);
    step(5);
    chk(count == c1, "R2 disable wins over enable", int'(count), int'(c1));
    issue(3'b110);
    chk(count == 0 && wave_a == 1, "R8 trigger while stopping", int'(count), 0);
    step(5);
    chk(count == 0 && wave_a == 1, "R9 hold after stop plus trigger", int'(count), 0);
    issue(3'b001);
    chk(count == 0, "R2 enable not yet counting", int'(count), 0);
    step(1);
    chk(count == 1, "R2 enable counts next cycle", int'(count), 1);
  endtask

  task automatic t_prescale;
    logic [15:0] c0;
    issue(3'b110);
    wr(0, mk(3'd1, NO, NO, NO, NO, NO, NO));
    wr(3, 16'hFFFF);
    issue(3'b001);
    step(2);
    c0 = count; step(40);
    chk(count == c0 + 16'd10, "R3 divide by 4", int'(count - c0), 10);
    wr(0, mk(3'd2, NO, NO, NO, NO, NO, NO));
    c0 = count; step(64);
    chk(count == c0 + 16'd4, "R3 divide by 16", int'(count - c0), 4);
    wr(0, mk(3'd4, NO, NO, NO, NO, NO, NO));
    c0 = count; step(20);
    chk(count == c0, "R3 slow select idle", int'(count - c0), 0);
    for (int i = 0; i < 3; i++) begin
      slow = 1'b1; step(1); slow = 1'b0; step(2);
    end
    chk(count == c0 + 16'd3, "R3 slow tick pulses", int'(count - c0), 3);
    wr(0, mk(3'd5, NO, NO, NO, NO, NO, NO));
    c0 = count; step(20);
    chk(count == c0, "R3 reserved select", int'(count - c0), 0);
  endtask

  task automatic t_toggle;
    int flips = 0;
    logic prev;
    issue(3'b110);
    wr(0, mk(3'd0, TG, NO, CL, NO, NO, NO));
    wr(1, 16'd2); wr(3, 16'd5);
    issue(3'b101);
    prev = wave_a;
    for (int i = 0; i < 18; i++) begin
      step(1);
      if (wave_a != prev) flips++;
      prev = wave_a;
    end
    chk(flips == 3, "R5 toggle once per period", flips, 3);
  endtask

  task automatic t_period_wins;
    int lows = 0;
    wr(0, mk(3'd0, CL, ST, CL, NO, NO, NO));
    wr(1, 16'd4); wr(3, 16'd4);
    issue(3'b101);
    chk(wave_a == 0, "R8 trigger clear", int'(wave_a), 0);
    step(6);
    chk(wave_a == 1, "R7 period action on coincident compare", int'(wave_a), 1);
    for (int i = 0; i < 14; i++) begin
      step(1);
      if (!wave_a) lows++;
    end
    chk(lows == 0, "R7 duty compare suppressed", lows, 0);
  endtask

  task automatic t_trig_wins;
    int guard = 0;
    wr(0, mk(3'd0, NO, ST, CL, NO, NO, ST));
    wr(1, 16'd1); wr(3, 16'd3);
    issue(3'b101);
    while (count != 16'd3 && guard < 10) begin
      step(1);
      guard++;
    end
    chk(count == 3 && wave_a == 0, "R8 setup before coincident trigger", int'(count), 3);
    issue(3'b100);
    chk(count == 0, "R8 trigger over wrap", int'(count), 0);
    chk(wave_a == 0 && wave_b == 1, "R8 trigger over period action", int'({wave_a, wave_b}), 1);
  endtask

  task automatic t_fixed;
    int bad = 0;
    logic [15:0] c0;
    wr(0, mk(3'd0, NO, NO, ST, NO, NO, NO));
    wr(1, 16'd2); wr(3, 16'd5);
    issue(3'b101);
    c0 = count;
    for (int i = 0; i < 15; i++) begin
      step(1);
      if (!wave_a) bad++;
    end
    chk(bad == 0 && count != c0, "R10 held high while running", bad, 0);
    wr(0, mk(3'd0, NO, NO, CL, NO, NO, NO));
    issue(3'b100);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (wave_a) bad++;
    end
    chk(bad == 0, "R10 held low while running", bad, 0);
  endtask

  task automatic t_rewrite;
    int bad = 0;
    wr(0, mk(3'd0, CL, ST, ST, NO, NO, NO));
    wr(1, 16'd3); wr(3, 16'd9);
    issue(3'b101);
    step(5);
    wr(1, 16'd7);
    step(10);
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (wave_a != (count <= 16'd7)) bad++;
    end
    chk(bad == 0, "R11 new duty value used", bad, 0);
  endtask

  initial begin
    fork
      begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_pwm();
        t_stop();
        t_prescale();
        t_toggle();
        t_period_wins();
        t_trig_wins();
        t_fixed();
        t_rewrite();
      end
      begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule